// File: doc/BRIEF.md
# Receive Time-Out Counter

This block is a 16-bit down-counter that a command byte can switch into a receive time-out mode. In that mode the counter is driven by the receive data stream. Each character moved from the receive shift register into the receive FIFO re-arms the counter from a 16-bit reload value, which is written as two separate bytes. If the counter runs down to zero before another character arrives, a sticky ready flag is set. The ready flag drives an interrupt request when the mask bit allows it.

A host uses this mode to learn that a message has ended and left data in the FIFO. It also uses it to learn that the line has been idle for longer than the programmed interval. The reload value is set a little above one character time.

Outside time-out mode the counter keeps only a plain start/stop counting function. In time-out mode those start and stop commands are locked out.

Top module: `rx_timeout_timer`

## Requirements
- R1: After reset, ctrReady, irqReq and countOut are all 0, the block is in normal mode and the counter is halted.
- R2: The reload value is {high byte, low byte}. reloadHiWr stores reloadData as bits 15:8 and reloadLoWr stores it as bits 7:0. A load copies the stored value into countOut on the next cycle.
- R3: A command write whose upper nibble is 0xA enters time-out mode, whatever its lower nibble. It clears ctrReady and halts the counter with its value held, until the next character strobe.
- R4: A command write whose upper nibble is 0xC leaves time-out mode, whatever its lower nibble. It clears ctrReady and halts the counter.
- R5: In time-out mode, the start command (upper nibble 0x8) and the stop command (upper nibble 0x9) have no effect on the count or on ctrReady.
- R6: In time-out mode, a charXfer pulse re-arms the counter, and the count does not change in that cycle.
  - The next tick loads the reload value, with the counter stopped.
  - The tick after that restarts the counter without decrementing.
  - Every later tick decrements the count by one.
  - A charXfer that comes during any step starts the sequence over.
  - A charXfer takes priority over a tick in the same cycle.
- R7: When the counter is running and a tick brings the count to 0, ctrReady is set. A reload value of 0 sets it on the first running tick. ctrReady stays set until an enter, exit or start command.
- R8: irqReq is 1 exactly when ctrReady is 1 and irqMask is 1.
- R9: Once the count reaches 0, the counter holds at 0. It does not reload until a new charXfer in time-out mode, or a start command in normal mode.
- R10: In normal mode:
  - A start command loads the reload value, clears ctrReady and runs the counter, which decrements once per tick.
  - A stop command halts the counter with its value held.
  - charXfer is ignored.
- R11: A command write in the same cycle as charXfer takes effect, and that charXfer is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter clock enable, one pulse per count step |
| charXfer | input | 1 | Pulse: a character was moved into the receive FIFO |
| cmdWr | input | 1 | Command write strobe |
| cmdData | input | 8 | Command byte; upper nibble selects the action |
| reloadHiWr | input | 1 | Write reloadData into the reload high byte |
| reloadLoWr | input | 1 | Write reloadData into the reload low byte |
| reloadData | input | 8 | Reload byte data |
| irqMask | input | 1 | Interrupt mask bit for the ready flag |
| ctrReady | output | 1 | Sticky counter-ready status flag |
| irqReq | output | 1 | Masked interrupt request |
| countOut | output | 16 | Current counter value |

## Verification
The time-out path is driven four ways:
- An undisturbed run to zero shows the two-tick stop/load/restart gap before decrementing starts.
- A character arriving in the middle of a count shows that every character re-arms the counter.
- A character landing on the same cycle as a tick, or as a command, tells the priority order apart.
- Start and stop commands issued inside time-out mode show the lockout, because the count keeps its course.

Normal-mode runs show the following: the reload byte order, that characters are ignored outside time-out mode, the hold at zero, and that a zero reload value sets ready on the first tick.

// File: rtl/rto_pkg.sv
package rto_pkg;

  typedef struct packed {
    logic enterTo;
    logic exitTo;
    logic startCnt;
    logic stopCnt;
  } cmdEv_t;

  typedef struct packed {
    logic load;
    logic dec;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_HALT   = 2'd0,
    ST_ARM    = 2'd1,
    ST_LOADED = 2'd2,
    ST_RUN    = 2'd3
  } cntState_t;

endpackage

// File: rtl/rto_cmd_decode.sv
module rto_cmd_decode
  import rto_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter logic [3:0] CODE_ENTER = 4'hA,
  parameter logic [3:0] CODE_EXIT  = 4'hC,
  parameter logic [3:0] CODE_START = 4'h8,
  parameter logic [3:0] CODE_STOP  = 4'h9
) (
  input  logic             cmdWr,
  input  logic [CMD_W-1:0] cmdData,
  output cmdEv_t           cmdEv
);

  localparam int OP_HI = CMD_W - 1;
  localparam int OP_LO = CMD_W - 4;

  logic [3:0] opCode;

  assign opCode = cmdData[OP_HI:OP_LO];

  always_comb begin
    cmdEv          = '0;
    cmdEv.enterTo  = cmdWr && (opCode == CODE_ENTER);
    cmdEv.exitTo   = cmdWr && (opCode == CODE_EXIT);
    cmdEv.startCnt = cmdWr && (opCode == CODE_START);
    cmdEv.stopCnt  = cmdWr && (opCode == CODE_STOP);
  end

endmodule

// File: rtl/rto_ctrl.sv
module rto_ctrl
  import rto_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       charXfer,
  input  cmdEv_t     cmdEv,
  input  logic       cntLow,
  output ctlStrobe_t strobe,
  output logic       ready,
  output logic       toMode
);

  cntState_t st, nextSt;
  logic      nextReady, nextMode;

  always_comb begin
    nextSt    = st;
    nextReady = ready;
    nextMode  = toMode;
    strobe    = '0;
    if (cmdEv.enterTo) begin
      nextMode  = 1'b1;
      nextReady = 1'b0;
      nextSt    = ST_HALT;
    end else if (cmdEv.exitTo) begin
      nextMode  = 1'b0;
      nextReady = 1'b0;
      nextSt    = ST_HALT;
    end else if (!toMode && cmdEv.startCnt) begin
      strobe.load = 1'b1;
      nextReady   = 1'b0;
      nextSt      = ST_RUN;
    end else if (!toMode && cmdEv.stopCnt) begin
      nextSt = ST_HALT;
    end else if (toMode && charXfer) begin
      nextSt = ST_ARM;
    end else if (tick) begin
      case (st)
        ST_ARM: begin
          strobe.load = 1'b1;
          nextSt      = ST_LOADED;
        end
        ST_LOADED: nextSt = ST_RUN;
        ST_RUN: begin
          strobe.dec = 1'b1;
          if (cntLow) begin
            nextReady = 1'b1;
            nextSt    = ST_HALT;
          end
        end
        default: nextSt = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_HALT;
      ready  <= 1'b0;
      toMode <= 1'b0;
    end else begin
      st     <= nextSt;
      ready  <= nextReady;
      toMode <= nextMode;
    end
  end

  // R3
  enter_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdEv.enterTo |=> (!ready && toMode));

  // R4
  exit_clears_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdEv.exitTo |=> (!ready && !toMode));

  // R7
  ready_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(tick));

  // R5
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toMode && (cmdEv.startCnt || cmdEv.stopCnt) && !charXfer && !tick)
      |=> ($stable(st) && $stable(ready)));

endmodule

// File: rtl/rto_data.sv
module rto_data
  import rto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hiWr,
  input  logic               loWr,
  input  logic [CNT_W/2-1:0] wrByte,
  input  ctlStrobe_t         strobe,
  output logic [CNT_W-1:0]   count,
  output logic               cntLow
);

  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] reloadHi, reloadLo;
  logic [CNT_W-1:0]  reloadVal;

  assign reloadVal = {reloadHi, reloadLo};
  assign cntLow    = (count <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadHi <= '0;
      reloadLo <= '0;
    end else begin
      if (hiWr) reloadHi <= wrByte;
      if (loWr) reloadLo <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= reloadVal;
    end else if (strobe.dec && (count != '0)) begin
      count <= count - CNT_W'(1);
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (count == $past(reloadVal)));

  // R9
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((count == '0) && !strobe.load) |=> (count == '0));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.load && (count != '0)) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/rx_timeout_timer.sv
module rx_timeout_timer
  import rto_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CMD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               charXfer,
  input  logic               cmdWr,
  input  logic [CMD_W-1:0]   cmdData,
  input  logic               reloadHiWr,
  input  logic               reloadLoWr,
  input  logic [CNT_W/2-1:0] reloadData,
  input  logic               irqMask,
  output logic               ctrReady,
  output logic               irqReq,
  output logic [CNT_W-1:0]   countOut
);

  cmdEv_t     cmdEv;
  ctlStrobe_t strobe;
  logic       cntLow;
  logic       toMode;

  rto_cmd_decode #(.CMD_W(CMD_W)) uDec (
    .cmdWr   (cmdWr),
    .cmdData (cmdData),
    .cmdEv   (cmdEv)
  );

  rto_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .charXfer (charXfer),
    .cmdEv    (cmdEv),
    .cntLow   (cntLow),
    .strobe   (strobe),
    .ready    (ctrReady),
    .toMode   (toMode)
  );

  rto_data #(.CNT_W(CNT_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .hiWr   (reloadHiWr),
    .loWr   (reloadLoWr),
    .wrByte (reloadData),
    .strobe (strobe),
    .count  (countOut),
    .cntLow (cntLow)
  );

  assign irqReq = ctrReady && irqMask;

endmodule

// File: tb/sim_rx_timeout_timer.sv
module sim_rx_timeout_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, charXfer = 1'b0, cmdWr = 1'b0;
  logic [7:0]  cmdData = '0;
  logic        reloadHiWr = 1'b0, reloadLoWr = 1'b0;
  logic [7:0]  reloadData = '0;
  logic        irqMask = 1'b0;
  logic        ctrReady, irqReq;
  logic [15:0] countOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  string       tagQ[$];
  logic [17:0] expQ[$];
  event        sampleEv;

  always #4 clk = ~clk;

  rx_timeout_timer u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .charXfer(charXfer),
    .cmdWr(cmdWr), .cmdData(cmdData), .reloadHiWr(reloadHiWr),
    .reloadLoWr(reloadLoWr), .reloadData(reloadData), .irqMask(irqMask),
    .ctrReady(ctrReady), .irqReq(irqReq), .countOut(countOut)
  );

  // Monitor: pops each expectation and compares it with the outputs.
  initial begin
    forever begin
      @(sampleEv);
      while (tagQ.size() > 0) begin
        string       t;
        logic [17:0] e;
        t = tagQ.pop_front();
        e = expQ.pop_front();
        vectors++;
        if ({ctrReady, irqReq, countOut} !== e) begin
          miscompares++;
          $display("FAIL %s: actual rdy=%0b irq=%0b cnt=%h expected rdy=%0b irq=%0b cnt=%h",
                   t, ctrReady, irqReq, countOut, e[17], e[16], e[15:0]);
        end
      end
    end
  end

  task automatic expect_out(input string t, input logic r, input logic i, input logic [15:0] c);
    tagQ.push_back(t);
    expQ.push_back({r, i, c});
    ->sampleEv;
    #0;
  endtask

  // One clock cycle of stimulus; inputs change 2 ns after the rising edge.
  task automatic cyc(input logic tk, input logic xf, input logic cw, input logic [7:0] cd,
                     input logic hw, input logic lw, input logic [7:0] dt);
    tick = tk; charXfer = xf; cmdWr = cw; cmdData = cd;
    reloadHiWr = hw; reloadLoWr = lw; reloadData = dt;
    @(posedge clk);
    #2;
    tick = 1'b0; charXfer = 1'b0; cmdWr = 1'b0; reloadHiWr = 1'b0; reloadLoWr = 1'b0;
  endtask

  task automatic tk1();  cyc(1, 0, 0, 8'h00, 0, 0, 8'h00); endtask
  task automatic cmd(input logic [7:0] c); cyc(0, 0, 1, c, 0, 0, 8'h00); endtask
  task automatic ch();   cyc(0, 1, 0, 8'h00, 0, 0, 8'h00); endtask
  task automatic setReload(input logic [7:0] hi, input logic [7:0] lo);
    cyc(0, 0, 0, 8'h00, 1, 0, hi);
    cyc(0, 0, 0, 8'h00, 0, 1, lo);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    expect_out("R1 reset state", 0, 0, 16'h0000);

    setReload(8'h00, 8'h05);
    expect_out("R2 reload write leaves count", 0, 0, 16'h0000);
    cmd(8'hA0);
    expect_out("R3 enter timeout", 0, 0, 16'h0000);
    repeat (3) tk1();
    expect_out("R3 halted until char", 0, 0, 16'h0000);
    cmd(8'h80); tk1();
    expect_out("R5 start ignored in timeout", 0, 0, 16'h0000);

    ch();
    expect_out("R6 char cycle no change", 0, 0, 16'h0000);
    tk1();
    expect_out("R6 first tick loads", 0, 0, 16'h0005);
    tk1();
    expect_out("R6 second tick restarts", 0, 0, 16'h0005);
    for (int k = 4; k >= 1; k--) begin
      tk1();
      expect_out("R6 decrement", 0, 0, 16'(k));
    end
    tk1();
    expect_out("R7 ready at zero", 1, 0, 16'h0000);
    repeat (3) tk1();
    expect_out("R9 hold at zero", 1, 0, 16'h0000);
    irqMask = 1'b1;
    cyc(0, 0, 0, 8'h00, 0, 0, 8'h00);
    expect_out("R8 masked irq on", 1, 1, 16'h0000);

    cmd(8'hA5);
    expect_out("R3 enter clears ready, low nibble ignored", 0, 0, 16'h0000);
    ch(); tk1(); tk1(); tk1(); tk1();
    expect_out("R6 mid count", 0, 0, 16'h0003);
    cyc(1, 1, 0, 8'h00, 0, 0, 8'h00);
    expect_out("R6 char beats tick", 0, 0, 16'h0003);
    tk1(); tk1(); tk1();
    expect_out("R6 restart after new char", 0, 0, 16'h0004);
    cmd(8'h90);
    expect_out("R5 stop ignored, count held", 0, 0, 16'h0004);
    tk1();
    expect_out("R5 still running after stop", 0, 0, 16'h0003);

    cyc(0, 1, 1, 8'hA0, 0, 0, 8'h00);
    tk1(); tk1();
    expect_out("R11 command wins over char", 0, 0, 16'h0003);

    ch(); tk1(); tk1();
    repeat (5) tk1();
    expect_out("R7 ready with irq", 1, 1, 16'h0000);
    cmd(8'hC7);
    expect_out("R4 exit clears ready", 0, 0, 16'h0000);

    setReload(8'h12, 8'h34);
    cmd(8'h80);
    expect_out("R2 byte order on start", 0, 0, 16'h1234);
    tk1();
    expect_out("R10 normal decrement", 0, 0, 16'h1233);
    cyc(1, 1, 0, 8'h00, 0, 0, 8'h00);
    expect_out("R10 char ignored in normal", 0, 0, 16'h1232);
    cmd(8'h90); tk1(); tk1();
    expect_out("R10 stop halts", 0, 0, 16'h1232);

    setReload(8'h00, 8'h00);
    cmd(8'h80);
    expect_out("R9 zero reload loaded", 0, 0, 16'h0000);
    tk1();
    expect_out("R7 zero reload sets ready", 1, 1, 16'h0000);
    irqMask = 1'b0;
    cyc(0, 0, 0, 8'h00, 0, 0, 8'h00);
    expect_out("R8 mask off", 1, 0, 16'h0000);
    setReload(8'h00, 8'h02);
    cmd(8'h80);
    expect_out("R10 start clears ready", 0, 0, 16'h0002);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule